// File: doc/BRIEF.md
# Configuration Word CRC Checker

This block keeps a running 32-bit checksum over the words of a configuration stream and checks it against an expected value whenever a check strobe arrives. It folds each accepted word into the checksum in one clock cycle, using the Castagnoli (CRC32C) generator polynomial. Data bits enter most significant first. No input or output reflection is applied, and there is no final inversion. Upstream logic has already parsed packets, so each word, each check and each clear shows up here as its own strobe.

If a comparison succeeds, the block gives a single-cycle pass pulse and the checksum starts over from zero. If a comparison fails, an error flag is raised and stays up. While the flag is up, the checker refuses every further word, check and clear. Only a program reset or an abort request removes the error. Either one also returns the checksum to zero. No comparison happens without a check strobe, so a stream that has lost word alignment and never sends a check is never flagged.

Top module: `cfgcrc_checker`

## Requirements
- R1: After reset is deasserted, `crc_value` is 0x00000000 and both `crc_err` and `crc_pass` are 0.
- R2: Each cycle with `word_vld` high folds `word_data` into the checksum, bit 31 first, with generator 0x1EDC6F41, no reflection and no final XOR. The result appears on `crc_value` after the next rising edge. Starting from zero, the word 0x00000001 gives 0x1EDC6F41.
- R3: When `crc_clr` is high, the checksum is reset to zero. If `word_vld` is high in the same cycle, that word is folded into the zero value, so the result equals the word's checksum from zero.
- R4: When `word_vld` and `chk_vld` are high together, the word is folded first, and the comparison uses the updated checksum.
- R5: When a check matches, `crc_pass` is high for exactly the one cycle after the check, and `crc_value` reads zero in that same cycle.
- R6: When a check does not match, `crc_err` goes high after the next edge. `crc_value` then holds the checksum that was compared, and `crc_pass` stays low.
- R7: While `crc_err` is high, `word_vld`, `chk_vld` and `crc_clr` have no effect. `crc_value` is held, `crc_pass` stays 0 and `crc_err` stays 1.
- R8: `prog_rst` or `abort_req` clears `crc_err`, `crc_pass` and the checksum after the next edge. This takes priority over any word, check or clear in the same cycle.
- R9: Without `chk_vld`, `crc_err` and `crc_pass` never change to 1, whatever words arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | Fold `word_data` this cycle |
| word_data | input | 32 | Configuration word |
| chk_vld | input | 1 | Compare the checksum against `chk_value` this cycle |
| chk_value | input | 32 | Expected checksum |
| crc_clr | input | 1 | Reset the checksum to zero |
| prog_rst | input | 1 | Program reset: clears the error and the checksum |
| abort_req | input | 1 | Abort: clears the error and the checksum |
| crc_err | output | 1 | Sticky mismatch flag |
| crc_pass | output | 1 | One-cycle pulse after a matching check |
| crc_value | output | 32 | Running checksum |

## Verification
The bench focuses on how strobes are ordered within one cycle. It checks a word that arrives with a check: a design that compared the old value would fail good streams. It checks a word that arrives with a clear: a design that cleared after folding would drop that word. It checks recovery arriving together with other strobes: a design that let a word through would start from a nonzero checksum. It also sends words, checks and clears while the error is latched; a design that leaked any of these would change `crc_value` or raise a pass pulse. Finally, it sends a long run of words with no check, which would expose a design that compares without being asked.

// File: rtl/cfgcrc_pkg.sv
package cfgcrc_pkg;
   localparam int unsigned CRC32C_W = 32;
   localparam logic [31:0] CRC32C_POLY = 32'h1EDC6F41;

   typedef enum logic [1:0] {
      ACC_HOLD = 2'd0,
      ACC_LOAD = 2'd1,
      ACC_INIT = 2'd2
   } acc_act_e;
endpackage

// File: rtl/cfgcrc_fold.sv
module cfgcrc_fold #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CRC_W = 32,
   parameter logic [CRC_W-1:0] POLY = 32'h1EDC6F41,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);
   localparam int unsigned STEPS = DATA_W;

   if (CRC_W < 8 || CRC_W > 64) begin : g_bad_crc_w
      $error("cfgcrc_fold: CRC_W out of range");
   end
   if (DATA_W < 1 || DATA_W > 128) begin : g_bad_data_w
      $error("cfgcrc_fold: DATA_W out of range");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("cfgcrc_fold: generator must have a constant term");
   end

   logic [CRC_W-1:0] stage [STEPS+1];

   assign stage[0] = crc_in;

   for (genvar i = 0; i < STEPS; i++) begin : g_step
      localparam int unsigned BIDX = MSB_FIRST ? (DATA_W - 1 - i) : i;
      logic fb;
      assign fb = stage[i][CRC_W-1] ^ data_in[BIDX];
      assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
   end

   assign crc_out = stage[STEPS];
endmodule

// File: rtl/cfgcrc_accum.sv
module cfgcrc_accum
   import cfgcrc_pkg::*;
#(
   parameter int unsigned CRC_W = 32,
   parameter logic [CRC_W-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  acc_act_e         act,
   input  logic [CRC_W-1:0] load_val,
   output logic [CRC_W-1:0] crc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= INIT;
      end else begin
         unique case (act)
            ACC_LOAD: crc_q <= load_val;
            ACC_INIT: crc_q <= INIT;
            default:  crc_q <= crc_q;
         endcase
      end
   end

   p_act_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      act inside {ACC_HOLD, ACC_LOAD, ACC_INIT});
   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACC_HOLD) |=> $stable(crc_q));
endmodule

// File: rtl/cfgcrc_ctrl.sv
module cfgcrc_ctrl
   import cfgcrc_pkg::*;
#(
   parameter int unsigned CRC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_vld,
   input  logic [CRC_W-1:0] chk_value,
   input  logic             recover,
   input  logic [CRC_W-1:0] cand_val,
   output acc_act_e         act,
   output logic             err_q,
   output logic             pass_q
);
   logic match;
   logic chk_ok;
   logic chk_bad;

   assign match   = (cand_val == chk_value);
   assign chk_ok  = chk_vld && match && !err_q;
   assign chk_bad = chk_vld && !match && !err_q;

   always_comb begin
      if (recover)      act = ACC_INIT;
      else if (err_q)   act = ACC_HOLD;
      else if (chk_ok)  act = ACC_INIT;
      else              act = ACC_LOAD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         pass_q <= 1'b0;
      end else if (recover) begin
         err_q  <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         pass_q <= chk_ok;
         if (chk_bad) err_q <= 1'b1;
      end
   end

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !recover) |=> err_q);
   p_no_pass_in_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !recover) |=> !pass_q);
   p_recover_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> (!err_q && !pass_q));
   p_err_needs_check_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(chk_vld));
   p_pass_needs_check_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pass_q |-> $past(chk_vld));
endmodule

// File: rtl/cfgcrc_checker.sv
module cfgcrc_checker
   import cfgcrc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CRC_W = CRC32C_W,
   parameter logic [CRC_W-1:0] POLY = CRC32C_POLY,
   parameter logic [CRC_W-1:0] INIT = '0,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld,
   input  logic [DATA_W-1:0] word_data,
   input  logic              chk_vld,
   input  logic [CRC_W-1:0]  chk_value,
   input  logic              crc_clr,
   input  logic              prog_rst,
   input  logic              abort_req,
   output logic              crc_err,
   output logic              crc_pass,
   output logic [CRC_W-1:0]  crc_value
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] base_val;
   logic [CRC_W-1:0] folded;
   logic [CRC_W-1:0] cand_val;
   logic             recover;
   acc_act_e         act;

   assign recover  = prog_rst || abort_req;
   assign base_val = crc_clr ? INIT : crc_q;

   cfgcrc_fold #(
      .DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .MSB_FIRST(MSB_FIRST)
   ) u_fold (
      .crc_in(base_val), .data_in(word_data), .crc_out(folded)
   );

   assign cand_val = word_vld ? folded : base_val;

   cfgcrc_ctrl #(.CRC_W(CRC_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .chk_vld(chk_vld), .chk_value(chk_value),
      .recover(recover), .cand_val(cand_val), .act(act),
      .err_q(crc_err), .pass_q(crc_pass)
   );

   cfgcrc_accum #(.CRC_W(CRC_W), .INIT(INIT)) u_acc (
      .clk(clk), .rst_n(rst_n), .act(act), .load_val(cand_val), .crc_q(crc_q)
   );

   assign crc_value = crc_q;

   p_pass_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      crc_pass |-> (crc_q == INIT));
   p_recover_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> (crc_q == INIT));
   p_err_holds_crc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_err && !recover) |=> $stable(crc_q));
endmodule

// File: tb/cfgcrc_checker_test.sv
`timescale 1ns/1ps
module cfgcrc_checker_test;
   localparam logic [31:0] GEN = 32'h1EDC6F41;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word_vld = 1'b0;
   logic [31:0] word_data = '0;
   logic        chk_vld = 1'b0;
   logic [31:0] chk_value = '0;
   logic        crc_clr = 1'b0;
   logic        prog_rst = 1'b0;
   logic        abort_req = 1'b0;
   logic        crc_err;
   logic        crc_pass;
   logic [31:0] crc_value;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [31:0] m_crc = '0;
   logic        m_err = 1'b0;
   logic        m_pass = 1'b0;
   logic [31:0] lcg = 32'h1234_5678;

   always #2.5 clk = ~clk;

   cfgcrc_checker uut (
      .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_data(word_data),
      .chk_vld(chk_vld), .chk_value(chk_value), .crc_clr(crc_clr),
      .prog_rst(prog_rst), .abort_req(abort_req), .crc_err(crc_err),
      .crc_pass(crc_pass), .crc_value(crc_value)
   );

   function automatic logic [31:0] mfold(logic [31:0] c, logic [31:0] d);
      for (int b = 31; b >= 0; b--) begin
         logic fb;
         fb = c[31] ^ d[b];
         c = c << 1;
         if (fb) c = c ^ GEN;
      end
      return c;
   endfunction

   function automatic logic [31:0] next_rand();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg;
   endfunction

   task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      check32(tag, "crc_value", crc_value, m_crc);
      check32(tag, "crc_err", {31'b0, crc_err}, {31'b0, m_err});
      check32(tag, "crc_pass", {31'b0, crc_pass}, {31'b0, m_pass});
   endtask

   task automatic step(bit wv, logic [31:0] w, bit cv, logic [31:0] ex,
                       bit clr, bit prg, bit abt, string tag);
      logic [31:0] base;
      logic [31:0] nv;
      word_vld = wv; word_data = w; chk_vld = cv; chk_value = ex;
      crc_clr = clr; prog_rst = prg; abort_req = abt;
      @(posedge clk);
      if (prg || abt) begin
         m_crc = '0; m_err = 1'b0; m_pass = 1'b0;
      end else if (m_err) begin
         m_pass = 1'b0;
      end else begin
         base = clr ? 32'h0 : m_crc;
         nv = wv ? mfold(base, w) : base;
         m_pass = 1'b0;
         if (cv && nv == ex) begin
            m_pass = 1'b1; m_crc = '0;
         end else begin
            if (cv) m_err = 1'b1;
            m_crc = nv;
         end
      end
      @(negedge clk);
      word_vld = 0; chk_vld = 0; crc_clr = 0; prog_rst = 0; abort_req = 0;
      compare(tag);
   endtask

   task automatic word(logic [31:0] w, string tag);
      step(1, w, 0, '0, 0, 0, 0, tag);
   endtask

   task automatic idle(string tag);
      step(0, '0, 0, '0, 0, 0, 0, tag);
   endtask

   initial begin
      logic [31:0] held;
      logic [31:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      word(32'h0000_0001, "R2");
      check32("R2", "known vector", crc_value, 32'h1EDC6F41);
      for (int i = 0; i < 20; i++) word(next_rand(), "R2");
      idle("R2");

      // R4: word plus check together, expected computed after the fold
      w = next_rand();
      step(1, w, 1, mfold(m_crc, w), 0, 0, 0, "R4");
      check32("R5", "pass pulse", {31'b0, crc_pass}, 32'd1);
      check32("R5", "crc restarted", crc_value, 32'h0);
      idle("R5");
      check32("R5", "pulse width", {31'b0, crc_pass}, 32'd0);

      // R3: clear with a word in the same cycle
      for (int i = 0; i < 4; i++) word(next_rand(), "R2");
      w = next_rand();
      step(1, w, 0, '0, 1, 0, 0, "R3");
      check32("R3", "clear then fold", crc_value, mfold(32'h0, w));
      step(0, '0, 0, '0, 1, 0, 0, "R3");
      check32("R3", "clear alone", crc_value, 32'h0);

      // check alone, matching
      for (int i = 0; i < 3; i++) word(next_rand(), "R2");
      step(0, '0, 1, m_crc, 0, 0, 0, "R5");

      // R6: mismatch
      for (int i = 0; i < 3; i++) word(next_rand(), "R2");
      held = m_crc;
      step(0, '0, 1, ~m_crc, 0, 0, 0, "R6");
      check32("R6", "err set", {31'b0, crc_err}, 32'd1);
      check32("R6", "crc kept", crc_value, held);

      // R7: everything ignored while error latched
      for (int i = 0; i < 5; i++) word(next_rand(), "R7");
      step(0, '0, 0, '0, 1, 0, 0, "R7");
      step(1, 32'h0000_0001, 1, 32'h0, 1, 0, 0, "R7");
      step(0, '0, 1, held, 0, 0, 0, "R7");
      check32("R7", "crc held", crc_value, held);
      check32("R7", "no pass", {31'b0, crc_pass}, 32'd0);

      // R8: abort with a word in the same cycle
      step(1, next_rand(), 1, '0, 0, 0, 1, "R8");
      check32("R8", "abort clears err", {31'b0, crc_err}, 32'd0);
      check32("R8", "abort clears crc", crc_value, 32'h0);

      for (int i = 0; i < 4; i++) word(next_rand(), "R2");
      step(0, '0, 1, 32'hDEAD_BEEF, 0, 0, 0, "R6");
      step(1, next_rand(), 1, '0, 1, 1, 0, "R8");
      check32("R8", "program clears", crc_value, 32'h0);
      for (int i = 0; i < 2; i++) word(next_rand(), "R2");
      w = next_rand();
      step(1, w, 1, mfold(m_crc, w), 0, 0, 0, "R4");

      // R9: long run with no check strobe
      for (int i = 0; i < 200; i++) word(next_rand(), "R9");
      check32("R9", "no err without check", {31'b0, crc_err}, 32'd0);
      step(0, '0, 0, '0, 0, 1, 0, "R8");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule